// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in, first-out store of 64 words of 8 bits. It is addressed by a 6-bit pointer that wraps modulo 64. The host raises `push_req` with a word on `push_data` to store it, or raises `pop_req` to get back the most recently stored word. The word arrives on `pop_data` one cycle later, marked by `pop_valid`.

Two flags track the fill state: `full` and `empty`. The block keeps no separate item counter. A push advances the pointer first and then writes at the new position. A pop reads at the current position and then moves the pointer back. Both flags therefore mark the pointer returning to zero, and location 0 holds the 64th item.

Some requests are refused and leave the state unchanged: a push while full, a pop while empty, and a push and pop in the same cycle. Each of these raises `err` for one cycle.

Top module: `reg_stack`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `err`, `pop_valid` and `pop_data` are 0.
- R2: Popped words come out in reverse order of their pushes. Each pop returns the most recent word that has not yet been popped.
- R3: A pop that is accepted drives `pop_data` and raises `pop_valid` for exactly one cycle, in the cycle after the request. A refused request leaves `pop_valid` low.
- R4: `full` rises on the push that stores the 64th item. The word stored by that push is the first one popped afterwards.
- R5: `empty` rises on the pop that removes the last item, and any accepted push clears it.
- R6: A push while `full` is high stores nothing. It raises `err` for one cycle and leaves the flags and the contents unchanged.
- R7: A pop while `empty` is high returns nothing. It raises `err` for one cycle, and `pop_valid` stays low.
- R8: A push and a pop requested in the same cycle are both refused. `err` pulses, no data is returned, and the contents and flags are unchanged.
- R9: `full` and `empty` are never high together, and any accepted pop clears `full`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Store `push_data` on top of the stack |
| pop_req | input | 1 | Remove the top word and return it |
| push_data | input | 8 | Word to store |
| pop_data | output | 8 | Word returned by the last accepted pop |
| pop_valid | output | 1 | One-cycle marker that `pop_data` is new |
| full | output | 1 | All 64 locations hold data |
| empty | output | 1 | No data is held |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
The pointer is the only fill state, so if it goes wrong the flags go wrong too. A pointer off by one makes `full` or `empty` appear one operation early or late. It also makes the next pop return a neighbour's word, which shows on the first `pop_valid` after the fault. A refused request that still moves the pointer, or still writes, shows up when the stack is drained: words come out missing, duplicated or in the wrong order. The flags are compared against a model after every operation, and every returned word is compared against the model as it appears.

// File: rtl/reg_stack.sv
module reg_stack #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid,
  output logic          full,
  output logic          empty,
  output logic          err
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] sp;
  logic [AW-1:0] sp_up;
  logic [AW-1:0] sp_dn;
  logic          do_push;
  logic          do_pop;
  logic          bad;

  assign sp_up   = sp + 1'b1;
  assign sp_dn   = sp - 1'b1;
  assign bad     = (push_req & pop_req) | (push_req & full) | (pop_req & empty);
  assign do_push = push_req & ~pop_req & ~full;
  assign do_pop  = pop_req & ~push_req & ~empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      err       <= 1'b0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else begin
      err       <= bad;
      pop_valid <= do_pop;
      if (do_push) begin
        sp    <= sp_up;
        full  <= (sp_up == '0);
        empty <= 1'b0;
      end else if (do_pop) begin
        pop_data <= mem[sp];
        sp       <= sp_dn;
        empty    <= (sp_dn == '0);
        full     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[sp_up] <= push_data;
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R9
  AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (full || empty) |-> (sp == '0)); // R4
  AST_POP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !empty) |=> (pop_valid && !err && !full)); // R3
  AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !full) |=> !empty); // R5
  AST_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && full) |=> (err && full && $stable(sp))); // R6
  AST_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && empty) |=> (err && empty && !pop_valid)); // R7
  AST_BOTH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> (err && !pop_valid && $stable(sp) && $stable(full) && $stable(empty))); // R8
endmodule

// File: tb/reg_stack_tb.sv
module reg_stack_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_req = 1'b0;
  logic       pop_req = 1'b0;
  logic [7:0] push_data = '0;
  logic [7:0] pop_data;
  logic       pop_valid;
  logic       full;
  logic       empty;
  logic       err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model[$];
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_stack u_dut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .pop_data(pop_data), .pop_valid(pop_valid),
    .full(full), .empty(empty), .err(err)
  );

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic op(input bit p, input bit q, input logic [7:0] d, input string tag);
    bit e_err;
    bit e_val;
    e_err = (p && q) || (p && model.size() == 64) || (q && model.size() == 0);
    e_val = q && !p && model.size() > 0;
    if (!e_err) begin
      if (p) model.push_back(d);
      if (q) exp_q.push_back(model.pop_back());
    end
    push_req  = p;
    pop_req   = q;
    push_data = d;
    @(negedge clk);
    push_req = 1'b0;
    pop_req  = 1'b0;
    chk(int'(err), int'(e_err), tag, "err");
    chk(int'(pop_valid), int'(e_val), "R3", "pop_valid");
    chk(int'(full), int'(model.size() == 64), "R4", "full");
    chk(int'(empty), int'(model.size() == 0), "R5", "empty");
    chk(int'(full && empty), 0, "R9", "full&empty");
  endtask

  always @(negedge clk) begin
    if (rst_n && pop_valid) begin
      if (exp_q.size() == 0) begin
        chk(1, 0, "R2", "unexpected pop_valid");
      end else begin
        chk(int'(pop_data), int'(exp_q.pop_front()), "R2", "pop_data");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, 1, "watchdog", "timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(int'(empty), 1, "R1", "empty");
    chk(int'(full), 0, "R1", "full");
    chk(int'(err), 0, "R1", "err");
    chk(int'(pop_valid), 0, "R1", "pop_valid");
    chk(int'(pop_data), 0, "R1", "pop_data");

    op(1'b0, 1'b1, 8'h00, "R7");
    op(1'b1, 1'b0, 8'h11, "R2");
    op(1'b1, 1'b0, 8'h22, "R2");
    op(1'b1, 1'b0, 8'h33, "R2");
    op(1'b1, 1'b1, 8'hEE, "R8");
    op(1'b0, 1'b1, 8'h00, "R2");
    op(1'b1, 1'b0, 8'h44, "R2");
    for (int i = 0; i < 4; i++) op(1'b0, 1'b1, 8'h00, "R5");
    op(1'b0, 1'b1, 8'h00, "R7");
    op(1'b1, 1'b1, 8'h55, "R8");

    for (int i = 0; i < 64; i++) op(1'b1, 1'b0, 8'(8'hA0 ^ i * 7), "R4");
    op(1'b1, 1'b0, 8'hFF, "R6");
    op(1'b1, 1'b1, 8'hFE, "R8");
    op(1'b0, 1'b1, 8'h00, "R9");
    op(1'b1, 1'b0, 8'h5A, "R4");
    op(1'b1, 1'b0, 8'h5B, "R6");
    for (int i = 0; i < 64; i++) op(1'b0, 1'b1, 8'h00, "R5");
    op(1'b0, 1'b1, 8'h00, "R7");

    for (int i = 0; i < 20; i++) begin
      op(1'b1, 1'b0, 8'(i * 13 + 1), "R2");
      op(1'b1, 1'b0, 8'(i * 29 + 3), "R2");
      op(1'b0, 1'b1, 8'h00, "R2");
    end
    for (int i = 0; i < 20; i++) op(1'b0, 1'b1, 8'h00, "R5");

    @(negedge clk);
    @(negedge clk);
    chk(exp_q.size(), 0, "R2", "outstanding pops");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule